// File: doc/BRIEF.md
# Serial Power-Controller Bridge Bring-Up Sequencer

This block brings a host-to-power-controller bridge from reset to operation. After a `start` pulse it walks through a fixed bring-up order. Every access goes through one command port, with a request held until `done`. An access is either a write to a local bridge register or a read or write of a register in the remote chip behind the serial link. The sequencer first pulses the bridge reset. It then sets up clock gating and resets the remote slave. It opens only the secondary host channel in the arbiter and hands delay calibration to an external helper through a start/done handshake. After that it reprograms the remote register-clock field and loads matching link waveform timings. It switches the link to dual-IO and proves it with a fixed-value read. It runs a write/read-back test, enables the signature check on both sides, and finally opens the arbiter and the two remaining channels.

Every read-back is checked on the spot. The first mismatch, access error, calibration failure or timeout stops the sequence. The sequencer then reports a 4-bit code for the stage that failed and stays halted until reset. When every stage passes, all three init-done flags rise together and stay high.

Top module: `pmic_bridge_init_seq`

## Requirements
- R1: After reset `cmd_req`, `cal_start`, `blk_rst`, `init_done` and `err_code` are all 0. A `start` pulse raises `blk_rst` for exactly RST_CYC cycles. No command or calibration start is issued while `blk_rst` is high.
- R2: A request holds `cmd_req`, `cmd_op`, `cmd_addr` and `cmd_wdata` stable until the cycle in which `cmd_done` is seen. One `cmd_done` completes exactly one command. `cmd_op` encodes 0 as local write, 1 as remote read, 2 as remote write and 3 as wait-for-idle; `cmd_wdata` is 0 for reads and wait-for-idle.
- R3: On success the command stream is exactly, as (op, addr, data) in hex: (0,00,3) (0,01,0) (2,10,1) (0,02,1) (0,03,004) (0,06,1) [calibration] (1,11,0) (2,11,clock value) (1,11,0) (0,07,rd-dummy) (0,08,cs-high-write) (0,09,cs-high-read) (0,0A,cs-low-start) (0,0B,cs-low-end) (2,12,1) (3,00,0) (0,0C,1) (1,13,0) (2,14,A55A) (1,14,0) (2,15,1) (0,0D,1) (0,03,1FF) (0,04,1) (0,05,1).
- R4: Before calibration only bit 2 (the secondary channel, value 0x004) is written to the arbiter mask. `cal_start` is a single-cycle pulse issued once. A `cal_done` with `cal_fail` set ends the run with code 3.
- R5: The clock value written to remote register 0x11 equals the value read from it with bits [11:10] forced to 01 when `clk_opt`=0 (18 MHz) and to 00 otherwise. If the second read of 0x11 differs from that value, the run ends with code 4.
- R6: The five waveform writes carry (rd-dummy, cs-high-write, cs-high-read, cs-low-start, cs-low-end) = (C,0,4,0,4) for `clk_opt`=0, (C,0,4,2,2) for `clk_opt`=1, and F for all five when `clk_opt` is 2 or 3.
- R7: A dual-IO test read of 0x13 that does not return 5A5A ends the run with code 5.
- R8: A read-back of 0x14 that does not return A55A ends the run with code 6.
- R9: A `cmd_err` on any access ends the run with the code of its stage: 1 through the slave reset, 2 for the arbiter writes, 4 for the clock stage, 5 for the dual-IO stage, 6 for the write test and 7 from the signature enable on.
- R10: A command left without `cmd_done` for TMO_CYC cycles is dropped and fails its stage. A calibration left without `cal_done` for CAL_TMO cycles fails with code 3.
- R11: Once `err_code` is non-zero it holds its value. No command or `cal_start` follows, `init_done` stays 0, and `start` is ignored until reset.
- R12: After the last command all three `init_done` bits rise in the same cycle with `err_code`=0 and stay high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begins the bring-up from idle |
| clk_opt | input | 2 | Register clock choice: 0 18 MHz, 1 26 MHz, 2/3 safe |
| cmd_req | output | 1 | Command request held until done |
| cmd_op | output | 2 | Command kind |
| cmd_addr | output | AW | Register address |
| cmd_wdata | output | DW | Write data |
| cmd_done | input | 1 | Command completed this cycle |
| cmd_err | input | 1 | Completed command reported an error |
| cmd_rdata | input | DW | Read data, valid with cmd_done |
| cal_start | output | 1 | One-cycle start of delay calibration |
| cal_done | input | 1 | Calibration finished |
| cal_fail | input | 1 | Calibration found no working delay |
| blk_rst | output | 1 | Bridge reset pulse |
| init_done | output | 3 | Bring-up complete flags |
| err_code | output | 4 | Failing stage code, 0 when none |

## Verification
The assertions check the port-level rules on every cycle. These are the quiet reset window, stable requests until completion, the single-cycle calibration pulse, the per-command timeout bound, the frozen error state and the all-or-nothing done flags. Whether the right registers receive the right values in the right order can only be shown by the bench scenarios. The same holds for the clock-field arithmetic, each waveform set and the mapping of every fault to its stage code. The bench runs each clock option to success and injects one fault per stage: an access error, corrupted or ignored remote data, a failed calibration, a missing calibration answer and a command that never completes.

// File: rtl/pmic_init_pkg.sv
package pmic_init_pkg;

   typedef enum logic [1:0] {OP_LWR = 2'd0, OP_RRD = 2'd1, OP_RWR = 2'd2, OP_IDLE = 2'd3} op_e;
   typedef enum logic [1:0] {K_RST, K_CMD, K_CAL, K_FIN} kind_e;
   typedef enum logic [1:0] {WD_CONST, WD_SAVED, WD_WRT} wsrc_e;
   typedef enum logic [1:0] {CK_NONE, CK_SAVED, CK_RDT, CK_WRT} chk_e;

   // local bridge registers
   localparam logic [7:0] LA_GATE_EN  = 8'h00;
   localparam logic [7:0] LA_GATE_DBC = 8'h01;
   localparam logic [7:0] LA_BRG_EN   = 8'h02;
   localparam logic [7:0] LA_ARB_MASK = 8'h03;
   localparam logic [7:0] LA_CH0_EN   = 8'h04;
   localparam logic [7:0] LA_CH1_EN   = 8'h05;
   localparam logic [7:0] LA_CH2_EN   = 8'h06;
   localparam logic [7:0] LA_WAVE0    = 8'h07;
   localparam logic [7:0] LA_DIO_EN   = 8'h0C;
   localparam logic [7:0] LA_SIG_EN   = 8'h0D;
   // remote chip registers
   localparam logic [7:0] RA_SLV_RST  = 8'h10;
   localparam logic [7:0] RA_CLK_CTL  = 8'h11;
   localparam logic [7:0] RA_DIO_EN   = 8'h12;
   localparam logic [7:0] RA_RD_TEST  = 8'h13;
   localparam logic [7:0] RA_WR_TEST  = 8'h14;
   localparam logic [7:0] RA_SIG_EN   = 8'h15;

   localparam logic [3:0] EC_NONE = 4'd0;
   localparam logic [3:0] EC_RST  = 4'd1;
   localparam logic [3:0] EC_ARB  = 4'd2;
   localparam logic [3:0] EC_CAL  = 4'd3;
   localparam logic [3:0] EC_CLK  = 4'd4;
   localparam logic [3:0] EC_DIO  = 4'd5;
   localparam logic [3:0] EC_WRT  = 4'd6;
   localparam logic [3:0] EC_SIG  = 4'd7;

   localparam int NUM_STEPS = 28;
   localparam int NUM_WAVE  = 5;

   typedef struct packed {
      kind_e       kind;
      op_e         op;
      logic [7:0]  addr;
      wsrc_e       wsrc;
      logic [15:0] wconst;
      chk_e        chk;
      logic        cap;
      logic [3:0]  ecode;
   } step_t;

   function automatic step_t mk_step(kind_e k, op_e o, logic [7:0] a, wsrc_e w,
                                     logic [15:0] d, chk_e c, logic cp, logic [3:0] e);
      step_t s;
      s.kind = k; s.op = o; s.addr = a; s.wsrc = w;
      s.wconst = d; s.chk = c; s.cap = cp; s.ecode = e;
      return s;
   endfunction

endpackage

// File: rtl/pmic_init_steps.sv
module pmic_init_steps
   import pmic_init_pkg::*;
#(
   parameter int SW = 5
)(
   input  logic [SW-1:0] idx,
   input  logic [1:0]    opt,
   output step_t         step
);

   // timing set per clock option: n = 0 dummy, 1/2 cs-high wr/rd, 3/4 cs-low start/end
   function automatic logic [15:0] wave(logic [1:0] o, int n);
      logic [15:0] v;
      if (o > 2'd1) v = 16'hF;
      else begin
         case (n)
            0:       v = 16'hC;
            1:       v = 16'h0;
            2:       v = 16'h4;
            3:       v = (o == 2'd0) ? 16'h0 : 16'h2;
            default: v = (o == 2'd0) ? 16'h4 : 16'h2;
         endcase
      end
      return v;
   endfunction

   int i;
   always_comb begin
      i = int'(idx);
      case (i)
         0:  step = mk_step(K_RST, OP_LWR, 8'h00, WD_CONST, 16'h0, CK_NONE, 1'b0, EC_RST);
         1:  step = mk_step(K_CMD, OP_LWR, LA_GATE_EN, WD_CONST, 16'h3, CK_NONE, 1'b0, EC_RST);
         2:  step = mk_step(K_CMD, OP_LWR, LA_GATE_DBC, WD_CONST, 16'h0, CK_NONE, 1'b0, EC_RST);
         3:  step = mk_step(K_CMD, OP_RWR, RA_SLV_RST, WD_CONST, 16'h1, CK_NONE, 1'b0, EC_RST);
         4:  step = mk_step(K_CMD, OP_LWR, LA_BRG_EN, WD_CONST, 16'h1, CK_NONE, 1'b0, EC_ARB);
         5:  step = mk_step(K_CMD, OP_LWR, LA_ARB_MASK, WD_CONST, 16'h004, CK_NONE, 1'b0, EC_ARB);
         6:  step = mk_step(K_CMD, OP_LWR, LA_CH2_EN, WD_CONST, 16'h1, CK_NONE, 1'b0, EC_ARB);
         7:  step = mk_step(K_CAL, OP_LWR, 8'h00, WD_CONST, 16'h0, CK_NONE, 1'b0, EC_CAL);
         8:  step = mk_step(K_CMD, OP_RRD, RA_CLK_CTL, WD_CONST, 16'h0, CK_NONE, 1'b1, EC_CLK);
         9:  step = mk_step(K_CMD, OP_RWR, RA_CLK_CTL, WD_SAVED, 16'h0, CK_NONE, 1'b0, EC_CLK);
         10: step = mk_step(K_CMD, OP_RRD, RA_CLK_CTL, WD_CONST, 16'h0, CK_SAVED, 1'b0, EC_CLK);
         11, 12, 13, 14, 15:
             step = mk_step(K_CMD, OP_LWR, LA_WAVE0 + 8'(i - 11), WD_CONST,
                            wave(opt, i - 11), CK_NONE, 1'b0, EC_CLK);
         16: step = mk_step(K_CMD, OP_RWR, RA_DIO_EN, WD_CONST, 16'h1, CK_NONE, 1'b0, EC_DIO);
         17: step = mk_step(K_CMD, OP_IDLE, 8'h00, WD_CONST, 16'h0, CK_NONE, 1'b0, EC_DIO);
         18: step = mk_step(K_CMD, OP_LWR, LA_DIO_EN, WD_CONST, 16'h1, CK_NONE, 1'b0, EC_DIO);
         19: step = mk_step(K_CMD, OP_RRD, RA_RD_TEST, WD_CONST, 16'h0, CK_RDT, 1'b0, EC_DIO);
         20: step = mk_step(K_CMD, OP_RWR, RA_WR_TEST, WD_WRT, 16'h0, CK_NONE, 1'b0, EC_WRT);
         21: step = mk_step(K_CMD, OP_RRD, RA_WR_TEST, WD_CONST, 16'h0, CK_WRT, 1'b0, EC_WRT);
         22: step = mk_step(K_CMD, OP_RWR, RA_SIG_EN, WD_CONST, 16'h1, CK_NONE, 1'b0, EC_SIG);
         23: step = mk_step(K_CMD, OP_LWR, LA_SIG_EN, WD_CONST, 16'h1, CK_NONE, 1'b0, EC_SIG);
         24: step = mk_step(K_CMD, OP_LWR, LA_ARB_MASK, WD_CONST, 16'h1FF, CK_NONE, 1'b0, EC_SIG);
         25: step = mk_step(K_CMD, OP_LWR, LA_CH0_EN, WD_CONST, 16'h1, CK_NONE, 1'b0, EC_SIG);
         26: step = mk_step(K_CMD, OP_LWR, LA_CH1_EN, WD_CONST, 16'h1, CK_NONE, 1'b0, EC_SIG);
         default:
             step = mk_step(K_FIN, OP_LWR, 8'h00, WD_CONST, 16'h0, CK_NONE, 1'b0, EC_NONE);
      endcase
   end

endmodule

// File: rtl/pmic_init_timer.sv
module pmic_init_timer #(
   parameter int CW = 8
)(
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          en,
   input  logic [CW-1:0] limit,
   output logic          expired,
   output logic          first
);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   cnt_q <= '0;
      else if (clr) cnt_q <= '0;
      else if (en)  cnt_q <= cnt_q + 1'b1;
   end

   assign expired = en && (cnt_q == limit - 1'b1);
   assign first   = en && (cnt_q == '0);

endmodule

// File: rtl/pmic_init_rdchk.sv
module pmic_init_rdchk
   import pmic_init_pkg::*;
#(
   parameter int            DW  = 16,
   parameter logic [DW-1:0] RDT = '0,
   parameter logic [DW-1:0] WRT = '0
)(
   input  chk_e          chk,
   input  logic [DW-1:0] rdata,
   input  logic [DW-1:0] saved,
   output logic          ok
);

   always_comb begin
      unique case (chk)
         CK_SAVED: ok = (rdata == saved);
         CK_RDT:   ok = (rdata == RDT);
         CK_WRT:   ok = (rdata == WRT);
         default:  ok = 1'b1;
      endcase
   end

endmodule

// File: rtl/pmic_bridge_init_seq.sv
module pmic_bridge_init_seq
   import pmic_init_pkg::*;
#(
   parameter int          AW          = 16,
   parameter int          DW          = 16,
   parameter int          RST_CYC     = 250,
   parameter int          TMO_CYC     = 1024,
   parameter int          CAL_TMO     = 4096,
   parameter logic [15:0] RD_TEST_VAL = 16'h5A5A,
   parameter logic [15:0] WR_TEST_VAL = 16'hA55A
)(
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [1:0]    clk_opt,
   output logic          cmd_req,
   output logic [1:0]    cmd_op,
   output logic [AW-1:0] cmd_addr,
   output logic [DW-1:0] cmd_wdata,
   input  logic          cmd_done,
   input  logic          cmd_err,
   input  logic [DW-1:0] cmd_rdata,
   output logic          cal_start,
   input  logic          cal_done,
   input  logic          cal_fail,
   output logic          blk_rst,
   output logic [2:0]    init_done,
   output logic [3:0]    err_code
);

   localparam int NDONE   = 3;
   localparam int SW      = $clog2(NUM_STEPS);
   localparam int LIM_A   = (RST_CYC > TMO_CYC) ? RST_CYC : TMO_CYC;
   localparam int LIM_MAX = (LIM_A > CAL_TMO) ? LIM_A : CAL_TMO;
   localparam int CW      = $clog2(LIM_MAX + 1);
   localparam logic [DW-1:0] CLK_FIELD = DW'(16'h0C00);
   localparam logic [DW-1:0] CLK_SEL18 = DW'(16'h0400);

   if (AW < 8) begin : g_bad_aw
      $error("AW must be at least 8");
   end
   if (DW < 16) begin : g_bad_dw
      $error("DW must be at least 16");
   end
   if (RST_CYC < 1 || TMO_CYC < 2 || CAL_TMO < 2) begin : g_bad_lim
      $error("reset hold must be >= 1 and timeouts >= 2");
   end

   typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_FAIL, ST_DONE} st_e;

   st_e           st_q;
   logic [SW-1:0] step_q;
   logic [1:0]    opt_q;
   logic [DW-1:0] saved_q;
   logic [3:0]    err_q;

   step_t         cur;
   logic          run, adv, fail, rd_ok, t_exp, t_first;
   logic [CW-1:0] lim;
   logic [DW-1:0] clk_fixed;

   pmic_init_steps #(.SW(SW)) u_steps (
      .idx  (step_q),
      .opt  (opt_q),
      .step (cur)
   );

   pmic_init_timer #(.CW(CW)) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (!run || adv || fail),
      .en      (run),
      .limit   (lim),
      .expired (t_exp),
      .first   (t_first)
   );

   pmic_init_rdchk #(
      .DW  (DW),
      .RDT (DW'(RD_TEST_VAL)),
      .WRT (DW'(WR_TEST_VAL))
   ) u_rdchk (
      .chk   (cur.chk),
      .rdata (cmd_rdata),
      .saved (saved_q),
      .ok    (rd_ok)
   );

   assign run       = (st_q == ST_RUN);
   assign clk_fixed = (cmd_rdata & ~CLK_FIELD) | ((opt_q == 2'd0) ? CLK_SEL18 : '0);

   always_comb begin
      unique case (cur.kind)
         K_RST:   lim = CW'(RST_CYC);
         K_CMD:   lim = CW'(TMO_CYC);
         K_CAL:   lim = CW'(CAL_TMO);
         default: lim = CW'(1);
      endcase
   end

   always_comb begin
      adv  = 1'b0;
      fail = 1'b0;
      if (run) begin
         unique case (cur.kind)
            K_RST: adv = t_exp;
            K_CMD: begin
               if (cmd_done) begin
                  if (cmd_err || !rd_ok) fail = 1'b1;
                  else                   adv  = 1'b1;
               end else if (t_exp) begin
                  fail = 1'b1;
               end
            end
            K_CAL: begin
               if (cal_done) begin
                  if (cal_fail) fail = 1'b1;
                  else          adv  = 1'b1;
               end else if (t_exp) begin
                  fail = 1'b1;
               end
            end
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= ST_IDLE;
         step_q  <= '0;
         opt_q   <= 2'd0;
         saved_q <= '0;
         err_q   <= EC_NONE;
      end else begin
         unique case (st_q)
            ST_IDLE: if (start) begin
               st_q   <= ST_RUN;
               step_q <= '0;
               opt_q  <= clk_opt;
            end
            ST_RUN: begin
               if (fail) begin
                  st_q  <= ST_FAIL;
                  err_q <= cur.ecode;
               end else if (adv) begin
                  step_q <= step_q + 1'b1;
               end else if (cur.kind == K_FIN) begin
                  st_q <= ST_DONE;
               end
               if (cur.cap && cmd_done && !cmd_err) saved_q <= clk_fixed;
            end
            default: ;
         endcase
      end
   end

   always_comb begin
      unique case (cur.wsrc)
         WD_SAVED: cmd_wdata = saved_q;
         WD_WRT:   cmd_wdata = DW'(WR_TEST_VAL);
         default:  cmd_wdata = DW'(cur.wconst);
      endcase
   end

   assign cmd_req   = run && (cur.kind == K_CMD);
   assign cmd_op    = cur.op;
   assign cmd_addr  = AW'(cur.addr);
   assign blk_rst   = run && (cur.kind == K_RST);
   assign cal_start = run && (cur.kind == K_CAL) && t_first;
   assign err_code  = err_q;

   for (genvar g = 0; g < NDONE; g++) begin : g_done
      assign init_done[g] = (st_q == ST_DONE);
   end

endmodule

// File: rtl/pmic_bridge_init_chk.sv
module pmic_bridge_init_chk #(
   parameter int AW      = 16,
   parameter int DW      = 16,
   parameter int TMO_CYC = 1024
)(
   input logic          clk,
   input logic          rst_n,
   input logic          cmd_req,
   input logic [1:0]    cmd_op,
   input logic [AW-1:0] cmd_addr,
   input logic [DW-1:0] cmd_wdata,
   input logic          cmd_done,
   input logic          cal_start,
   input logic          blk_rst,
   input logic [2:0]    init_done,
   input logic [3:0]    err_code
);

   int wait_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     wait_cnt <= 0;
      else if (cmd_req && !cmd_done)  wait_cnt <= wait_cnt + 1;
      else                            wait_cnt <= 0;
   end

   assert_rst_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
      blk_rst |-> (!cmd_req && !cal_start));

   assert_req_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_req && !cmd_done) |=>
         ((cmd_req && $stable(cmd_op) && $stable(cmd_addr) && $stable(cmd_wdata))
          || (err_code != 4'd0)));

   assert_cal_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
      cal_start |=> !cal_start);

   assert_tmo_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_req |-> (wait_cnt < TMO_CYC));

   assert_halt_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (err_code != 4'd0) |=>
         ($stable(err_code) && !cmd_req && !cal_start && (init_done == 3'b000)));

   assert_done_all_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (init_done != 3'b000) |-> ((init_done == 3'b111) && (err_code == 4'd0) && !cmd_req));

   assert_done_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (init_done == 3'b111) |=> (init_done == 3'b111));

endmodule

bind pmic_bridge_init_seq pmic_bridge_init_chk #(
   .AW      (AW),
   .DW      (DW),
   .TMO_CYC (TMO_CYC)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cmd_req   (cmd_req),
   .cmd_op    (cmd_op),
   .cmd_addr  (cmd_addr),
   .cmd_wdata (cmd_wdata),
   .cmd_done  (cmd_done),
   .cal_start (cal_start),
   .blk_rst   (blk_rst),
   .init_done (init_done),
   .err_code  (err_code)
);

// File: tb/pmic_bridge_init_seq_tb.sv
module pmic_bridge_init_seq_tb;

   localparam int RST  = 25;
   localparam int TMO  = 40;
   localparam int CTMO = 100;
   localparam logic [15:0] RDT     = 16'h5A5A;
   localparam logic [15:0] WRT     = 16'hA55A;
   localparam logic [15:0] CLK_INI = 16'h0F5A;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [1:0]  clk_opt = 2'd0;
   logic        cmd_req;
   logic [1:0]  cmd_op;
   logic [15:0] cmd_addr;
   logic [15:0] cmd_wdata;
   logic        cmd_done = 1'b0;
   logic        cmd_err = 1'b0;
   logic [15:0] cmd_rdata = '0;
   logic        cal_start;
   logic        cal_done = 1'b0;
   logic        cal_fail = 1'b0;
   logic        blk_rst;
   logic [2:0]  init_done;
   logic [3:0]  err_code;

   always #2 clk = ~clk;

   pmic_bridge_init_seq #(
      .AW(16), .DW(16), .RST_CYC(RST), .TMO_CYC(TMO), .CAL_TMO(CTMO),
      .RD_TEST_VAL(RDT), .WR_TEST_VAL(WRT)
   ) u_dut (
      .clk(clk), .rst_n(rst_n), .start(start), .clk_opt(clk_opt),
      .cmd_req(cmd_req), .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
      .cmd_done(cmd_done), .cmd_err(cmd_err), .cmd_rdata(cmd_rdata),
      .cal_start(cal_start), .cal_done(cal_done), .cal_fail(cal_fail),
      .blk_rst(blk_rst), .init_done(init_done), .err_code(err_code)
   );

   int n_cmp = 0;
   int n_bad = 0;
   bit finished = 0;

   // scenario knobs
   int lat, err_idx, hang_idx, cal_lat;
   bit cal_bad, cal_hang, stuck_clk, stuck_wt, bad_rdt;

   // observation state
   int cmd_idx, wait_n, hold_len, rst_seen, cal_seen, cal_cnt;
   logic [15:0] rmem [0:31];
   logic [1:0]  q_op[$];
   logic [15:0] q_addr[$];
   logic [15:0] q_data[$];

   task automatic check(input string req, input string what, input int act, input int exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic push(input logic [1:0] o, input logic [15:0] a, input logic [15:0] d);
      q_op.push_back(o);
      q_addr.push_back(a);
      q_data.push_back(d);
   endtask

   // expected command stream (R3, R4, R5, R6)
   task automatic build(input logic [1:0] o);
      logic [15:0] w [5];
      logic [15:0] cv;
      q_op.delete(); q_addr.delete(); q_data.delete();
      if (o == 2'd0)      w = '{16'hC, 16'h0, 16'h4, 16'h0, 16'h4};
      else if (o == 2'd1) w = '{16'hC, 16'h0, 16'h4, 16'h2, 16'h2};
      else                w = '{16'hF, 16'hF, 16'hF, 16'hF, 16'hF};
      cv = (CLK_INI & ~16'h0C00) | ((o == 2'd0) ? 16'h0400 : 16'h0000);
      push(0, 16'h00, 16'h3); push(0, 16'h01, 16'h0); push(2, 16'h10, 16'h1);
      push(0, 16'h02, 16'h1); push(0, 16'h03, 16'h004); push(0, 16'h06, 16'h1);
      push(1, 16'h11, 16'h0); push(2, 16'h11, cv); push(1, 16'h11, 16'h0);
      for (int k = 0; k < 5; k++) push(0, 16'h07 + 16'(k), w[k]);
      push(2, 16'h12, 16'h1); push(3, 16'h00, 16'h0); push(0, 16'h0C, 16'h1);
      push(1, 16'h13, 16'h0); push(2, 16'h14, WRT); push(1, 16'h14, 16'h0);
      push(2, 16'h15, 16'h1); push(0, 16'h0D, 16'h1); push(0, 16'h03, 16'h1FF);
      push(0, 16'h04, 16'h1); push(0, 16'h05, 16'h1);
   endtask

   // responder and reference monitor, active at the falling edge
   initial begin
      forever begin
         @(negedge clk);
         cmd_done = 1'b0; cmd_err = 1'b0; cal_done = 1'b0; cal_fail = 1'b0;
         if (!rst_n) begin
            cmd_idx = 0; wait_n = 0; hold_len = 0; rst_seen = 0; cal_seen = 0; cal_cnt = 0;
         end else begin
            if (blk_rst) rst_seen++;
            if (cmd_req) begin
               if (wait_n == 0) begin
                  if (q_op.size() == 0) begin
                     check("R3", "unexpected command", 1, 0);
                  end else begin
                     check("R3", "op", cmd_op, q_op.pop_front());
                     check("R3", "addr", cmd_addr, q_addr.pop_front());
                     check("R3", "wdata", cmd_wdata, q_data.pop_front());
                  end
               end
               if (cmd_idx != hang_idx && wait_n >= lat) begin
                  if (cmd_op == 2'd2) begin
                     if (!(stuck_clk && cmd_addr == 16'h11) && !(stuck_wt && cmd_addr == 16'h14))
                        rmem[cmd_addr[4:0]] = cmd_wdata;
                  end else if (cmd_op == 2'd1) begin
                     cmd_rdata = rmem[cmd_addr[4:0]];
                     if (bad_rdt && cmd_addr == 16'h13) cmd_rdata = ~RDT;
                  end
                  cmd_err  = (cmd_idx == err_idx);
                  cmd_done = 1'b1;
                  cmd_idx++;
                  wait_n = 0;
               end else begin
                  wait_n++;
               end
            end else if (wait_n != 0) begin
               hold_len = wait_n;
               wait_n = 0;
            end
            if (cal_start) begin
               cal_seen++;
               cal_cnt = 1;
            end else if (cal_cnt > 0) begin
               cal_cnt++;
               if (cal_cnt == cal_lat + 1 && !cal_hang) begin
                  cal_done = 1'b1;
                  cal_fail = cal_bad;
                  cal_cnt = 0;
               end
            end
         end
      end
   end

   task automatic knobs_default();
      lat = 1; err_idx = -1; hang_idx = -1; cal_lat = 6;
      cal_bad = 0; cal_hang = 0; stuck_clk = 0; stuck_wt = 0; bad_rdt = 0;
   endtask

   task automatic run_case(input string name, input logic [1:0] o, input int exp_code);
      int n;
      bit busy_after;
      rst_n = 1'b0; start = 1'b0; clk_opt = o;
      for (int k = 0; k < 32; k++) rmem[k] = 16'h0;
      rmem[16'h11] = CLK_INI;
      rmem[16'h13] = RDT;
      build(o);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: quiet after reset
      check("R1", {name, " idle outputs"},
            {cmd_req, cal_start, blk_rst, init_done, err_code}, 0);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      n = 0;
      while (err_code == 4'd0 && init_done == 3'b000 && n < 4000) begin
         @(negedge clk);
         n++;
      end
      // R11: start is ignored and nothing is issued after the end
      busy_after = 0;
      start = 1'b1;
      for (int k = 0; k < 12; k++) begin
         @(negedge clk);
         start = 1'b0;
         if (cmd_req || cal_start) busy_after = 1;
      end
      check("R11", {name, " quiet after end"}, busy_after, 0);
      check("R9", {name, " error code"}, err_code, exp_code);
      check("R12", {name, " done flags"}, init_done, (exp_code == 0) ? 3'b111 : 3'b000);
      check("R1", {name, " reset pulse length"}, rst_seen, RST);
      if (exp_code == 0) begin
         check("R3", {name, " all commands issued"}, q_op.size(), 0);
         check("R4", {name, " one calibration start"}, cal_seen, 1);
      end
   endtask

   initial begin
      knobs_default();
      run_case("opt26", 2'd1, 0);                    // R3 R4 R6 R12
      knobs_default(); lat = 3;
      run_case("opt18", 2'd0, 0);                    // R5 R6 (18 MHz field = 01)
      knobs_default(); lat = 0;
      run_case("safe", 2'd2, 0);                     // R6 safe set, R2 zero-latency
      knobs_default(); err_idx = 2;
      run_case("slave_err", 2'd1, 1);                // R9 stage 1
      knobs_default(); cal_bad = 1;
      run_case("cal_fail", 2'd1, 3);                 // R4
      knobs_default(); stuck_clk = 1;
      run_case("clk_mismatch", 2'd0, 4);             // R5
      knobs_default(); bad_rdt = 1;
      run_case("dio_bad", 2'd1, 5);                  // R7
      knobs_default(); err_idx = 14;
      run_case("dio_err", 2'd1, 5);                  // R9 stage 5
      knobs_default(); stuck_wt = 1;
      run_case("wtest_bad", 2'd3, 6);                // R8
      knobs_default(); err_idx = 20;
      run_case("sig_err", 2'd1, 7);                  // R9 stage 7
      knobs_default(); hang_idx = 4;
      run_case("cmd_hang", 2'd1, 2);                 // R10
      check("R10", "request length before timeout", hold_len, TMO);
      knobs_default(); cal_hang = 1;
      run_case("cal_hang", 2'd1, 3);                 // R10 calibration timeout
      check("R4", "cal_hang one start", cal_seen, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      finished = 1;
      $finish;
   end

   initial begin
      for (int c = 0; c < 150000; c++) @(posedge clk);
      if (!finished) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

endmodule